// File: doc/BRIEF.md
# Receive Lock Monitor with Clock Fallback

This block watches the bit stream produced by a receive clock-recovery loop and decides whether that loop can be trusted. Each recovered bit arrives as a one-cycle strobe with its data value, and a separate strobe marks every reference word period. The nominal ratio is ten bits per reference tick. The block drops lock for two reasons. The first is a run of identical bits longer than a set bound, which means transitions are missing. The second is a measured bit count over a window of reference ticks that misses the nominal count by more than 1000 ppm. A single slipped or repeated bit, which is how a sudden phase jump appears, stays within that tolerance and does not drop lock.

The clock-source select follows the lock decision. It picks the recovered clock only while locked and falls back to the reference otherwise, so downstream logic keeps the correct frequency. Two sticky flags record which check caused the most recent loss. Both flags clear when lock is regained. Regaining lock takes an unbroken stretch of 250 bit strobes without a run-length fault, followed by one complete measurement window that passes.

Top module: `rx_lock_monitor`

## Requirements
- R1: While locked, the strobe that brings a run of equal bit values to RUN_LIMIT+1 (default 128) drops `locked` in the following cycle. A run of exactly RUN_LIMIT equal bits leaves lock untouched.
- R2: A window spans WIN_TICKS reference ticks. It counts bit strobes after its opening tick, up to and including the strobe in the cycle of its closing tick. The window fails when that count differs from BITS_PER_TICK·WIN_TICKS by more than floor(BITS_PER_TICK·WIN_TICKS·PPM_LIMIT/10^6), in either direction. A failing window while locked drops `locked` in the cycle after the closing tick.
- R3: `clk_sel` is 1 (recovered clock) exactly while `locked` is 1. It is 0 (reference clock) at all other times, including right after a loss.
- R4: A single missing bit strobe, or a break in the alternating data pattern, inside a window does not drop lock.
- R5: Lock acquisition works as follows. The clean-strobe count reaches ACQ_BITS (250). The next cycle arms a fresh window, whose opening tick is a tick in that cycle or the first tick after it. `locked` rises one cycle after that window closes and passes. From reset, with one strobe and alternating data every cycle and a tick every tenth cycle from the first cycle, lock first shows after the 1252nd cycle.
- R6: `loss_run` and `loss_rate` are set on a loss according to its cause (both when both causes occur on one edge). They hold while unlocked and both return to 0 when `locked` rises.
- R7: With `rst` high, `locked`, `clk_sel`, `loss_run` and `loss_rate` are all 0.
- R8: A run-length fault restarts the 250-strobe clean count. After a fault on strobe s, followed by one strobe every cycle, lock is still absent in cycle s+1250 and present by cycle s+1262.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One recovered bit is present this cycle |
| bit_val | input | 1 | Value of the recovered bit |
| ref_tick | input | 1 | One reference word period has elapsed |
| locked | output | 1 | Clock recovery judged in lock |
| clk_sel | output | 1 | 1 selects recovered clock, 0 selects reference |
| loss_run | output | 1 | Last loss caused by excessive run length |
| loss_rate | output | 1 | Last loss caused by rate error |

## Verification
The two loss detectors can fire on the same edge: a run-length fault can coincide with the closing tick of a window that fails. The bench removes twenty strobes early in a window, which guarantees a rate failure. It then computes how many cycles remain until the closing tick and fills exactly the final 129 of them with equal bits, so the run limit is exceeded on the closing tick itself. It expects `locked` to stay high through that cycle, then fall, with both `loss_run` and `loss_rate` set.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_RATE = 2'd1,
        ST_LOCK = 2'd2
    } lk_state_e;

    typedef struct packed {
        logic run;
        logic rate;
    } loss_cause_t;

    typedef struct packed {
        logic done;
        logic pass;
    } win_res_t;

    function automatic longint unsigned rate_tol(
        input longint unsigned win,
        input longint unsigned bpt,
        input longint unsigned ppm
    );
        return (win * bpt * ppm) / 64'd1000000;
    endfunction

endpackage

// File: rtl/rlm_run_tracker.sv
module rlm_run_tracker #(
    parameter int RUN_LIMIT = 128,
    parameter int ACQ_BITS  = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic bit_val,
    output logic run_viol,
    output logic streak_ok
);
    localparam int RW = $clog2(RUN_LIMIT + 2);
    localparam int SW = $clog2(ACQ_BITS + 1);
    localparam logic [RW-1:0] LIM    = RW'(RUN_LIMIT);
    localparam logic [RW-1:0] LIM_P1 = RW'(RUN_LIMIT + 1);
    localparam logic [SW-1:0] ACQ_C  = SW'(ACQ_BITS);

    logic          have_bit, last_bit, viol_q;
    logic [RW-1:0] run_len, run_nxt;
    logic [SW-1:0] streak, streak_nxt;
    logic          same, exceed, new_viol;

    always_comb begin
        same     = have_bit && (bit_val == last_bit);
        if (!same)
            run_nxt = RW'(1);
        else if (run_len == LIM_P1)
            run_nxt = run_len;
        else
            run_nxt = run_len + RW'(1);
        exceed   = (run_nxt == LIM_P1);
        new_viol = same && (run_len == LIM);
        if (exceed)
            streak_nxt = '0;
        else if (streak == ACQ_C)
            streak_nxt = streak;
        else
            streak_nxt = streak + SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_bit <= 1'b0;
            last_bit <= 1'b0;
            run_len  <= '0;
            streak   <= '0;
            viol_q   <= 1'b0;
        end else begin
            viol_q <= 1'b0;
            if (bit_stb) begin
                have_bit <= 1'b1;
                last_bit <= bit_val;
                run_len  <= run_nxt;
                streak   <= streak_nxt;
                viol_q   <= new_viol;
            end
        end
    end

    assign run_viol  = viol_q;
    assign streak_ok = (streak == ACQ_C);

    // R1: a fault pulse always stems from a bit strobe one edge earlier
    a_r1_viol_after_strobe: assert property (@(posedge clk) disable iff (rst)
        run_viol |-> $past(bit_stb));

    // R8: a fault leaves no completed clean streak behind it
    a_r8_streak_cleared: assert property (@(posedge clk) disable iff (rst)
        run_viol |-> !streak_ok);

endmodule

// File: rtl/rlm_rate_meter.sv
module rlm_rate_meter #(
    parameter int WIN_TICKS     = 10000,
    parameter int BITS_PER_TICK = 10,
    parameter int PPM_LIMIT     = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              ref_tick,
    input  logic              restart,
    output rlm_pkg::win_res_t res
);
    localparam longint unsigned EXP = 64'(WIN_TICKS) * 64'(BITS_PER_TICK);
    localparam longint unsigned TOL = rlm_pkg::rate_tol(64'(WIN_TICKS),
                                        64'(BITS_PER_TICK), 64'(PPM_LIMIT));
    localparam longint unsigned LO  = (TOL >= EXP) ? 64'd0 : EXP - TOL;
    localparam longint unsigned HI  = EXP + TOL;
    localparam int CW = $clog2(2 * EXP + 2);
    localparam int TW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam logic [CW-1:0] LO_C  = CW'(LO);
    localparam logic [CW-1:0] HI_C  = CW'(HI);
    localparam logic [CW-1:0] CMAX  = '1;
    localparam logic [TW-1:0] TLAST = TW'(WIN_TICKS - 1);

    logic          armed, done_q, pass_q;
    logic [TW-1:0] tick_cnt;
    logic [CW-1:0] bit_cnt, cnt_now;
    logic          close, in_range;

    always_comb begin
        cnt_now  = (bit_stb && (bit_cnt != CMAX)) ? bit_cnt + CW'(1) : bit_cnt;
        close    = armed && ref_tick && (tick_cnt == TLAST);
        in_range = (cnt_now >= LO_C) && (cnt_now <= HI_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            tick_cnt <= '0;
            bit_cnt  <= '0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            if (restart) begin
                armed    <= ref_tick;
                tick_cnt <= '0;
                bit_cnt  <= '0;
            end else if (!armed) begin
                if (ref_tick) begin
                    armed    <= 1'b1;
                    tick_cnt <= '0;
                    bit_cnt  <= '0;
                end
            end else if (close) begin
                done_q   <= 1'b1;
                pass_q   <= in_range;
                tick_cnt <= '0;
                bit_cnt  <= '0;
            end else begin
                bit_cnt <= cnt_now;
                if (ref_tick)
                    tick_cnt <= tick_cnt + TW'(1);
            end
        end
    end

    assign res.done = done_q;
    assign res.pass = pass_q;

    // R2: a window result only ever follows a reference tick
    a_r2_done_follows_tick: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(ref_tick));

    // R2: no verdict appears in the cycle after a restart request
    a_r2_no_done_after_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> !done_q);

endmodule

// File: rtl/rlm_lock_fsm.sv
module rlm_lock_fsm (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_viol,
    input  logic                 streak_ok,
    input  rlm_pkg::win_res_t    win,
    output logic                 restart,
    output logic                 lock_o,
    output logic                 sel_rec,
    output rlm_pkg::loss_cause_t cause
);
    import rlm_pkg::*;

    lk_state_e   state;
    loss_cause_t cause_q;
    logic        lose_run, lose_rate;

    always_comb begin
        lose_run  = (state == ST_LOCK) && run_viol;
        lose_rate = (state == ST_LOCK) && win.done && !win.pass;
        restart   = ((state == ST_HUNT) && streak_ok) ||
                    ((state == ST_RATE) && !run_viol && win.done && !win.pass);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            cause_q <= '0;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (streak_ok)
                        state <= ST_RATE;
                end
                ST_RATE: begin
                    if (run_viol)
                        state <= ST_HUNT;
                    else if (win.done && win.pass) begin
                        state   <= ST_LOCK;
                        cause_q <= '0;
                    end
                end
                ST_LOCK: begin
                    if (lose_run || lose_rate) begin
                        state        <= ST_HUNT;
                        cause_q.run  <= lose_run;
                        cause_q.rate <= lose_rate;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    assign lock_o  = (state == ST_LOCK);
    assign sel_rec = (state == ST_LOCK);
    assign cause   = cause_q;

    // R1: run fault while locked ends lock and records its cause
    a_r1_run_drops_lock: assert property (@(posedge clk) disable iff (rst)
        (lock_o && run_viol) |=> (!lock_o && cause.run));

    // R2: failing window while locked ends lock and records its cause
    a_r2_rate_drops_lock: assert property (@(posedge clk) disable iff (rst)
        (lock_o && win.done && !win.pass) |=> (!lock_o && cause.rate));

    // R5: lock only rises after a passing window verdict
    a_r5_lock_needs_pass: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(win.done && win.pass));

    // R6: both loss reasons are clear on re-lock
    a_r6_clear_on_relock: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> (!cause.run && !cause.rate));

endmodule

// File: rtl/rx_lock_monitor.sv
module rx_lock_monitor #(
    parameter int RUN_LIMIT     = 128,
    parameter int ACQ_BITS      = 250,
    parameter int WIN_TICKS     = 10000,
    parameter int BITS_PER_TICK = 10,
    parameter int PPM_LIMIT     = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic bit_val,
    input  logic ref_tick,
    output logic locked,
    output logic clk_sel,
    output logic loss_run,
    output logic loss_rate
);
    import rlm_pkg::*;

    logic        run_viol, streak_ok, restart;
    win_res_t    win;
    loss_cause_t cause;

    rlm_run_tracker #(
        .RUN_LIMIT (RUN_LIMIT),
        .ACQ_BITS  (ACQ_BITS)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .run_viol  (run_viol),
        .streak_ok (streak_ok)
    );

    rlm_rate_meter #(
        .WIN_TICKS     (WIN_TICKS),
        .BITS_PER_TICK (BITS_PER_TICK),
        .PPM_LIMIT     (PPM_LIMIT)
    ) u_rate (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (bit_stb),
        .ref_tick (ref_tick),
        .restart  (restart),
        .res      (win)
    );

    rlm_lock_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run_viol  (run_viol),
        .streak_ok (streak_ok),
        .win       (win),
        .restart   (restart),
        .lock_o    (locked),
        .sel_rec   (clk_sel),
        .cause     (cause)
    );

    assign loss_run  = cause.run;
    assign loss_rate = cause.rate;

    // R3: fallback select is on the reference whenever lock is absent
    a_r3_ref_when_unlocked: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> !clk_sel);

endmodule

// File: tb/sim_rx_lock_monitor.sv
`timescale 1ns/1ps
module sim_rx_lock_monitor;
    localparam int WIN = 100;
    localparam int LIM = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_stb = 1'b0, bit_val = 1'b0, ref_tick = 1'b0;
    logic locked, clk_sel, loss_run, loss_rate;

    int checks = 0, errors = 0;
    int gcnt = 0, ph = 0, tper = 10, tick_idx = 0, anchor = 0, viol_step = 0;
    logic bv = 1'b0, prev_lock = 1'b0, hung = 1'b0;

    always #2 clk = ~clk;

    rx_lock_monitor #(
        .RUN_LIMIT(LIM), .ACQ_BITS(250), .WIN_TICKS(WIN),
        .BITS_PER_TICK(10), .PPM_LIMIT(1000)
    ) u0 (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
        .ref_tick(ref_tick), .locked(locked), .clk_sel(clk_sel),
        .loss_run(loss_run), .loss_rate(loss_rate)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic b);
        bit_stb  = s;
        bit_val  = b;
        ref_tick = !rst && (ph == 0);
        @(posedge clk);
        #1;
        if (ref_tick) tick_idx++;
        if (!rst) begin
            ph = (ph + 1) % tper;
            gcnt++;
        end
        if (locked && !prev_lock) anchor = tick_idx;
        prev_lock = locked;
    endtask

    task automatic alt();
        bv = ~bv;
        step(1'b1, bv);
    endtask

    task automatic konst(input int n);
        logic v;
        v = ~bv;
        for (int i = 0; i < n; i++) step(1'b1, v);
        bv = v;
    endtask

    function automatic int next_close();
        return anchor + ((tick_idx - anchor) / WIN + 1) * WIN;
    endfunction

    function automatic int steps_to(input int t);
        return ((tper - ph) % tper) + 1 + (t - tick_idx - 1) * tper;
    endfunction

    task automatic finish_window();
        int t;
        t = next_close();
        while (tick_idx < t) alt();
    endtask

    task automatic wait_lock(input string tag, input int limit);
        int n;
        n = 0;
        while (!locked && n < limit) begin
            alt();
            n++;
        end
        chk({tag, " relock"}, locked, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        chk("R7 locked in reset", locked, 0);
        chk("R7 clk_sel in reset", clk_sel, 0);
        chk("R7 loss_run in reset", loss_run, 0);
        chk("R7 loss_rate in reset", loss_rate, 0);
        rst = 1'b0;
        ph = 0; gcnt = 0; tick_idx = 0; prev_lock = 1'b0;
    endtask

    task automatic t_acquire();
        while (gcnt < 1251) alt();
        chk("R5 no lock at cycle 1251", locked, 0);
        chk("R3 reference while hunting", clk_sel, 0);
        alt();
        chk("R5 lock at cycle 1252", locked, 1);
        chk("R3 recovered while locked", clk_sel, 1);
    endtask

    task automatic t_run_limit();
        konst(LIM);
        for (int i = 0; i < 5; i++) alt();
        chk("R1 run of exactly limit keeps lock", locked, 1);
        konst(LIM + 1);
        viol_step = gcnt;
        chk("R1 lock held on violating strobe cycle", locked, 1);
        alt();
        chk("R1 lock dropped after run fault", locked, 0);
        chk("R3 reference after run loss", clk_sel, 0);
        chk("R6 loss_run after run loss", loss_run, 1);
        chk("R6 loss_rate after run loss", loss_rate, 0);
    endtask

    task automatic t_run_relock();
        while (gcnt < viol_step + 1250) alt();
        chk("R8 clean count restarted", locked, 0);
        chk("R6 loss_run holds while hunting", loss_run, 1);
        while (gcnt < viol_step + 1262) alt();
        chk("R8 lock regained in bound", locked, 1);
        chk("R6 loss_run cleared on relock", loss_run, 0);
    endtask

    task automatic t_phase_jump();
        int t;
        finish_window();
        t = tick_idx + WIN;
        step(1'b0, bv);
        alt(); alt();
        step(1'b1, bv);
        while (tick_idx < t) alt();
        alt();
        chk("R4 slipped bit keeps lock", locked, 1);
        chk("R4 no rate loss flagged", loss_rate, 0);
    endtask

    task automatic t_rate_deficit();
        int t;
        finish_window();
        t = tick_idx + WIN;
        step(1'b0, bv);
        step(1'b0, bv);
        while (tick_idx < t) alt();
        chk("R2 lock held in closing tick cycle", locked, 1);
        alt();
        chk("R2 deficit of two drops lock", locked, 0);
        chk("R3 reference after rate loss", clk_sel, 0);
        chk("R6 loss_rate after deficit", loss_rate, 1);
        chk("R6 loss_run after deficit", loss_run, 0);
        wait_lock("R2 deficit", 1200);
        chk("R6 loss_rate cleared on relock", loss_rate, 0);
    endtask

    task automatic t_rate_surplus();
        int n;
        tper = 11;
        ph = ph % tper;
        n = 0;
        while (locked && n < 2400) begin
            alt();
            n++;
        end
        chk("R2 surplus drops lock", locked, 0);
        chk("R6 loss_rate after surplus", loss_rate, 1);
        tper = 10;
        ph = ph % tper;
        wait_lock("R2 surplus", 1200);
    endtask

    task automatic t_both();
        int t;
        finish_window();
        t = tick_idx + WIN;
        for (int i = 0; i < 20; i++) step(1'b0, bv);
        while (steps_to(t) > LIM + 1) alt();
        konst(LIM + 1);
        chk("R6 coincident close tick reached", tick_idx, t);
        chk("R1 lock held on coincident edge", locked, 1);
        alt();
        chk("R1 coincident loss drops lock", locked, 0);
        chk("R6 both causes loss_run", loss_run, 1);
        chk("R6 both causes loss_rate", loss_rate, 1);
    endtask

    initial begin
        #(200000 * 4);
        hung = 1'b1;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", gcnt, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_acquire();
        t_phase_jump();
        t_run_limit();
        t_run_relock();
        t_rate_deficit();
        t_rate_surplus();
        t_both();
        if (!hung) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule